// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog for a microcontroller-style system. It stays dormant after reset until software writes a two-byte key (1Eh followed by E1h) to one write-only service register. From then on it counts machine cycles, using a strobe that the clock generator supplies. Software must repeat the same key pair before the count runs out. If the count runs out, the block raises a one-clock reset request and drives a reset-out pulse of fixed length. Once armed, software cannot stop it. Only a hardware reset, or the end of its own reset-out pulse, returns it to the dormant state.

Two configuration inputs tailor its behaviour. One pauses counting while the system is idle. The other keeps the reset-out pin quiet while the internal reset request still fires. Counting always stops during power-down. After a wake-up through the wake interrupt, counting stays stopped until the wake line returns high, so that a long wake pulse cannot trigger a spurious timeout.

Top module: `svc_wdt`

## Requirements
- R1: After reset the watchdog is dormant: `rst_req_o` and `rst_out_o` are 0, and no number of `mc_tick_i` strobes produces a reset request until the block is armed.
- R2: A write of 1Eh followed by a write of E1h to address A6h arms the watchdog with a count of zero. The 16383rd counted strobe after arming is the overflow strobe. `rst_req_o` is 1 in the clock after that strobe's edge.
- R3: Writes to addresses other than A6h have no effect. While the block waits for the first key byte, any byte other than 1Eh has no effect. Any byte other than E1h after 1Eh discards the sequence, including a second 1Eh.
- R4: While the watchdog is armed, a completed 1Eh/E1h pair clears the count to zero, so the next overflow comes 16383 counted strobes later.
- R5: Once armed, no write sequence disarms the watchdog or changes its count, other than the clearing pair of R4.
- R6: On overflow, `rst_req_o` is high for exactly one clock. `rst_out_o` rises in that same clock and stays high for exactly 98 clocks.
- R7: When `cfg_rstout_off_i` is 1 at the overflow edge, `rst_out_o` stays 0 for that whole pulse, but `rst_req_o` is still asserted.
- R8: While `idle_i` is 1, strobes are counted if `cfg_idle_hold_i` is 0 and are ignored if it is 1. Counting resumes where it stopped.
- R9: While `pdown_i` is 1, no strobe is counted. After power-down, strobes stay uncounted while `wake_irq_ni` is 0. Counting resumes from the clock after the one in which `wake_irq_ni` is seen high with `pdown_i` low.
- R10: At the end of the reset-out pulse the watchdog is dormant again and can be armed anew with the same key pair.
- R11: The count advances only on clocks where `mc_tick_i` is 1, by one per strobe. Clocks without the strobe leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address; the service register sits at A6h |
| wr_data_i | input | 8 | Write data |
| mc_tick_i | input | 1 | Machine-cycle strobe, one clock per machine cycle |
| idle_i | input | 1 | System is in idle |
| pdown_i | input | 1 | System is in power-down |
| wake_irq_ni | input | 1 | Wake interrupt line, active low |
| cfg_idle_hold_i | input | 1 | 1: pause counting while idle |
| cfg_rstout_off_i | input | 1 | 1: keep the reset-out pin low on overflow |
| rst_req_o | output | 1 | One-clock reset request on overflow |
| rst_out_o | output | 1 | Reset-out drive, 98 clocks long |

## Verification
Several rules are checked by assertions on every cycle. The count stays frozen under power-down, under gated idle and on clocks without a strobe. A completed key pair always leaves a zero count. An armed watchdog stays armed until its pulse ends. The request lasts a single clock, and reset-out rises only together with it and never when the quiet bit was set. Other behaviours can only be shown by the bench's scenarios: the exact strobe count to overflow after arming or servicing, the 98-clock pulse length, the rejection of broken or misdirected key sequences, and the wake holdoff that lasts until the wake line goes high. The bench checks these against cycle counts it computes itself.

// File: rtl/svc_wdt_pkg.sv
package svc_wdt_pkg;

  // Progress through the two-byte service key.
  typedef enum logic [0:0] {
    KEY_WAIT_A = 1'b0,
    KEY_WAIT_B = 1'b1
  } key_state_e;

  localparam logic [7:0] DEF_SVC_ADDR = 8'hA6;
  localparam logic [7:0] DEF_KEY_A    = 8'h1E;
  localparam logic [7:0] DEF_KEY_B    = 8'hE1;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import svc_wdt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = ADDR_W'(DEF_SVC_ADDR),
  parameter logic [DATA_W-1:0] KEY_A    = DATA_W'(DEF_KEY_A),
  parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(DEF_KEY_B)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,   // reset-out pulse in progress
  input  logic              done_i,   // last clock of the pulse
  output logic              svc_o,    // key pair completed this clock
  output logic              armed_o
);

  key_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       hit;
  logic       svc;

  assign hit = wr_en_i && (wr_addr_i == SVC_ADDR);

  // Next-state logic for the key sequence and the armed flag.
  always_comb begin
    state_d = state_q;
    svc     = 1'b0;
    if (hit) begin
      unique case (state_q)
        KEY_WAIT_A: begin
          if (wr_data_i == KEY_A) state_d = KEY_WAIT_B;
        end
        KEY_WAIT_B: begin
          state_d = KEY_WAIT_A;
          if ((wr_data_i == KEY_B) && !busy_i) svc = 1'b1;
        end
        default: state_d = KEY_WAIT_A;
      endcase
    end

    armed_d = armed_q;
    if (done_i)   armed_d = 1'b0;
    else if (svc) armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KEY_WAIT_A;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign svc_o   = svc;
  assign armed_o = armed_q;

endmodule

// File: rtl/wdt_cycle_cnt.sv
module wdt_cycle_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             armed_i,
  input  logic             busy_i,
  input  logic             idle_i,
  input  logic             idle_hold_i,
  input  logic             pdown_i,
  input  logic             wake_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o,
  output logic             req_o
);

  // Overflow is declared on the strobe that would make the count all-ones.
  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             req_q, req_d;
  logic             run;
  logic             fire;

  // Clock enable of the counter, with every gating term written out.
  assign run  = tick_i && armed_i && !busy_i && !pdown_i && !hold_q
                && !(idle_i && idle_hold_i);
  assign fire = run && !clr_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == CNT_LAST) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end

    // Wake holdoff: set in power-down, released once the wake line is high.
    if (pdown_i) hold_d = 1'b1;
    else         hold_d = hold_q && !wake_ni;

    req_d = fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      req_q  <= req_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire;
  assign req_o  = req_q;

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_LEN = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic quiet_i,
  output logic active_o,
  output logic drive_o,
  output logic done_o
);

  localparam int            PW     = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_LEN - 1);

  logic          act_q, act_d;
  logic          drv_q, drv_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          done;

  assign done = act_q && (pcnt_q == P_LAST);

  // Runs on every oscillator clock, independent of the machine-cycle strobe.
  always_comb begin
    act_d  = act_q;
    drv_d  = drv_q;
    pcnt_d = pcnt_q;
    if (fire_i) begin
      act_d  = 1'b1;
      drv_d  = !quiet_i;
      pcnt_d = '0;
    end else if (act_q) begin
      if (done) begin
        act_d  = 1'b0;
        drv_d  = 1'b0;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      drv_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      drv_q  <= drv_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign active_o = act_q;
  assign drive_o  = drv_q;
  assign done_o   = done;

endmodule

// File: rtl/svc_wdt.sv
module svc_wdt
  import svc_wdt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                CNT_W     = 14,
  parameter int                PULSE_LEN = 98,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = ADDR_W'(DEF_SVC_ADDR),
  parameter logic [DATA_W-1:0] KEY_A     = DATA_W'(DEF_KEY_A),
  parameter logic [DATA_W-1:0] KEY_B     = DATA_W'(DEF_KEY_B)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mc_tick_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wake_irq_ni,
  input  logic              cfg_idle_hold_i,
  input  logic              cfg_rstout_off_i,
  output logic              rst_req_o,
  output logic              rst_out_o
);

  logic             svc_hit;
  logic             armed;
  logic             pulse_act;
  logic             pulse_done;
  logic             fire;
  logic [CNT_W-1:0] cnt_q;

  wdt_key_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SVC_ADDR (SVC_ADDR),
    .KEY_A    (KEY_A),
    .KEY_B    (KEY_B)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .busy_i    (pulse_act),
    .done_i    (pulse_done),
    .svc_o     (svc_hit),
    .armed_o   (armed)
  );

  wdt_cycle_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (mc_tick_i),
    .armed_i     (armed),
    .busy_i      (pulse_act),
    .idle_i      (idle_i),
    .idle_hold_i (cfg_idle_hold_i),
    .pdown_i     (pdown_i),
    .wake_ni     (wake_irq_ni),
    .clr_i       (svc_hit),
    .cnt_o       (cnt_q),
    .fire_o      (fire),
    .req_o       (rst_req_o)
  );

  wdt_rst_pulse #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .quiet_i  (cfg_rstout_off_i),
    .active_o (pulse_act),
    .drive_o  (rst_out_o),
    .done_o   (pulse_done)
  );

endmodule

// File: rtl/svc_wdt_chk.sv
module svc_wdt_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mc_tick_i,
  input logic             idle_i,
  input logic             pdown_i,
  input logic             cfg_idle_hold_i,
  input logic             cfg_rstout_off_i,
  input logic             rst_req_o,
  input logic             rst_out_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             armed,
  input logic             svc_hit,
  input logic             pulse_act
);

  // R1: a dormant watchdog never requests a reset in the next clock
  assert_unarmed_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !rst_req_o);

  // R4: a completed key pair leaves a zero count
  assert_svc_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_hit |=> (cnt_q == '0));

  // R5: only the end of the pulse can disarm
  assert_stay_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !pulse_act) |=> armed);

  // R6: the request lasts a single clock
  assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R6: reset-out rises only together with the request
  assert_out_with_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_out_o) |-> rst_req_o);

  // R7: the quiet bit at the overflow edge keeps reset-out low
  assert_quiet_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && $past(cfg_rstout_off_i)) |-> !rst_out_o);

  // R8: gated idle freezes the count
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && cfg_idle_hold_i && !svc_hit) |=> $stable(cnt_q));

  // R9: power-down freezes the count
  assert_pdown_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_i && !svc_hit) |=> $stable(cnt_q));

  // R10: the pulse ends with the watchdog dormant
  assert_pulse_disarm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_act) |-> !armed);

  // R11: no strobe, no count change
  assert_no_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mc_tick_i && !svc_hit) |=> $stable(cnt_q));

endmodule

bind svc_wdt svc_wdt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .mc_tick_i        (mc_tick_i),
  .idle_i           (idle_i),
  .pdown_i          (pdown_i),
  .cfg_idle_hold_i  (cfg_idle_hold_i),
  .cfg_rstout_off_i (cfg_rstout_off_i),
  .rst_req_o        (rst_req_o),
  .rst_out_o        (rst_out_o),
  .cnt_q            (cnt_q),
  .armed            (armed),
  .svc_hit          (svc_hit),
  .pulse_act        (pulse_act)
);

// File: tb/svc_wdt_tb_top.sv
module svc_wdt_tb_top;

  localparam int         LIMIT    = 16383;  // counted strobes to overflow
  localparam int         PULSE    = 98;
  localparam logic [7:0] A_SVC    = 8'hA6;
  localparam logic [7:0] K1       = 8'h1E;
  localparam logic [7:0] K2       = 8'hE1;
  localparam int         WD_LIMIT = 195000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [7:0] wr_addr_i;
  logic [7:0] wr_data_i;
  logic       mc_tick_i;
  logic       idle_i;
  logic       pdown_i;
  logic       wake_irq_ni;
  logic       cfg_idle_hold_i;
  logic       cfg_rstout_off_i;
  logic       rst_req_o;
  logic       rst_out_o;

  int n_run  = 0;
  int n_fail = 0;
  int req_seen = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  svc_wdt dut_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_en_i          (wr_en_i),
    .wr_addr_i        (wr_addr_i),
    .wr_data_i        (wr_data_i),
    .mc_tick_i        (mc_tick_i),
    .idle_i           (idle_i),
    .pdown_i          (pdown_i),
    .wake_irq_ni      (wake_irq_ni),
    .cfg_idle_hold_i  (cfg_idle_hold_i),
    .cfg_rstout_off_i (cfg_rstout_off_i),
    .rst_req_o        (rst_req_o),
    .rst_out_o        (rst_out_o)
  );

  // Count request clocks, sampled away from the active edge.
  always @(negedge clk_i) if (rst_req_o) req_seen <= req_seen + 1;

  // Expected request level after a given number of counted strobes.
  function automatic int exp_req(input int counted);
    return (counted == LIMIT) ? 1 : 0;
  endfunction

  function automatic int exp_drive(input bit quiet);
    return quiet ? 0 : 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      mc_tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      mc_tick_i = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk_i);
  endtask

  task automatic arm();
    wr(A_SVC, K1);
    wr(A_SVC, K2);
  endtask

  // Called at the sample where the request must be visible.
  task automatic check_pulse(input string tag, input bit quiet);
    int w;
    chk({tag, " R6 request"}, int'(rst_req_o), exp_req(LIMIT));
    chk({tag, " R6 out rise"}, int'(rst_out_o), exp_drive(quiet));
    settle();
    chk({tag, " R6 request one clock"}, int'(rst_req_o), 0);
    if (!quiet) begin
      w = 1;
      while (rst_out_o && w < 300) begin
        w++;
        settle();
      end
      chk({tag, " R6 out width"}, w, PULSE);
    end else begin
      w = 0;
      for (int i = 0; i < PULSE + 20; i++) begin
        if (rst_out_o) w++;
        settle();
      end
      chk({tag, " R7 out suppressed"}, w, 0);
    end
    repeat (PULSE + 10) settle();
  endtask

  task automatic junk_writes(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 255));
      if (a == A_SVC) a = A_SVC + 8'd1;
      wr(a, 8'($urandom_range(0, 255)));
    end
  endtask

  // Watchdog of the bench itself.
  initial begin
    repeat (WD_LIMIT) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    int base;
    void'($urandom(32'h5EED_1234));
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    mc_tick_i = 1'b0; idle_i = 1'b0; pdown_i = 1'b0; wake_irq_ni = 1'b1;
    cfg_idle_hold_i = 1'b0; cfg_rstout_off_i = 1'b0;
    repeat (4) settle();
    chk("R1 reset req", int'(rst_req_o), 0);
    chk("R1 reset out", int'(rst_out_o), 0);
    rst_ni = 1'b1;
    settle();

    // R1: dormant watchdog ignores strobes
    base = req_seen;
    ticks(LIMIT + 17);
    settle();
    chk("R1 dormant no request", req_seen - base, 0);

    // R3: misdirected and broken sequences leave it dormant
    base = req_seen;
    junk_writes(40);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      d = 8'($urandom_range(0, 255));
      if (d == K1) d = K1 + 8'd1;
      wr(A_SVC, d);
    end
    wr(A_SVC, K1); wr(A_SVC, 8'h55); wr(A_SVC, K2);
    wr(A_SVC, K1); wr(A_SVC, K1);    wr(A_SVC, K2);
    wr(8'hA5, K1); wr(8'hA7, K2);
    ticks(LIMIT + 17);
    settle();
    chk("R3 broken keys no request", req_seen - base, 0);

    // R2/R11: arm, idle clocks without strobe, exact overflow count
    arm();
    repeat (5000) settle();
    junk_writes(10);
    base = req_seen;
    ticks(LIMIT - 1);
    settle();
    chk("R2 R11 no early request", req_seen - base, exp_req(LIMIT - 1));
    ticks(1);
    check_pulse("R2 overflow", 1'b0);

    // R10: dormant after the pulse
    base = req_seen;
    ticks(LIMIT + 5);
    settle();
    chk("R10 dormant after pulse", req_seen - base, 0);

    // R5/R4/R7: disarm attempts, service, quiet overflow
    arm();
    k = $urandom_range(100, 9000);
    ticks(k);
    wr(A_SVC, 8'h00); wr(A_SVC, K1); wr(A_SVC, 8'h00);
    wr(8'hA5, K2); wr(A_SVC, K2);
    base = req_seen;
    ticks(LIMIT - k - 1);
    settle();
    chk("R5 still counting, no early request", req_seen - base, 0);
    arm();
    cfg_rstout_off_i = 1'b1;
    ticks(LIMIT - 1);
    settle();
    chk("R4 serviced count restarted", req_seen - base, 0);
    ticks(1);
    check_pulse("R4 R7 quiet overflow", 1'b1);
    cfg_rstout_off_i = 1'b0;

    // R8: idle counts with gate off, pauses with gate on
    arm();
    idle_i = 1'b1; cfg_idle_hold_i = 1'b0;
    ticks(3000);
    cfg_idle_hold_i = 1'b1;
    ticks(10000);
    idle_i = 1'b0; cfg_idle_hold_i = 1'b0;
    base = req_seen;
    ticks(LIMIT - 3000 - 1);
    settle();
    chk("R8 idle gating", req_seen - base, 0);
    ticks(1);
    check_pulse("R8 overflow", 1'b0);

    // R9: power-down and wake holdoff
    arm();
    ticks(2000);
    pdown_i = 1'b1; wake_irq_ni = 1'b0;
    ticks(5000);
    pdown_i = 1'b0;
    ticks(3000);
    wake_irq_ni = 1'b1;
    settle();
    base = req_seen;
    ticks(LIMIT - 2000 - 1);
    settle();
    chk("R9 power-down holdoff", req_seen - base, 0);
    ticks(1);
    check_pulse("R9 overflow", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule